// File: doc/BRIEF.md
# Polyphase Vertical Image Scaler

This block resamples one 8-bit video channel in the vertical direction. Each output row is a weighted mix of four neighbouring source rows. The weights come from a 32-phase table of four signed 8-bit taps per phase, and the taps of each phase add up to 64. Software first writes the table through a word-wide port and then commits it. After that, one frame-start pulse starts a frame that covers a programmed number of output lines and columns.

A 16.16 fixed-point position accumulator walks down the source image. It starts at a programmable fractional phase and grows by a programmable step after every output line. The step is normally the input height shifted left by 16 and divided by the output height. The integer part of the accumulator picks the centre source row. Its top fractional bits pick the filter phase. The block asks an external line buffer for the four source pixels of the current column, with the row numbers clamped at the image edges. It then forms the sum of products, rounds it and clamps it, and sends the result out on a valid/ready stream.

Top module: `vscale_vert`

## Requirements
- R1: During reset and in the first cycle after it, o_valid and busy are 0. The coefficient-ready flag is also clear, so a frame_start that follows reset has no effect.
- R2: The table has 32 words, selected by cf_idx (5 bits). In each word, bits 7:0 hold the signed weight for source row n-1, bits 15:8 the weight for row n, bits 23:16 the weight for row n+1 and bits 31:24 the weight for row n+2.
- R3: frame_start is accepted only when all of these hold: the ready flag is set, the block is not busy, and in_h, out_h and line_w are all non-zero. A cf_commit pulse sets the ready flag. Any cf_we clears it, and cf_we takes priority when both arrive in the same cycle. A frame_start that is not accepted has no effect.
- R4: An accepted frame_start loads the accumulator with integer part 0 and fractional part start_frac, and busy reads 1 in the next cycle.
- R5: For output line y the accumulator equals start_frac + y*step modulo 2^32. n is accumulator bits 31:16 and the phase is bits 15:11. step is added once, after the last column of each line.
- R6: lb_rows carries the four source rows n-1, n, n+1 and n+2, each clamped to the range 0..in_h-1. Field k occupies bits 12k+11:12k. lb_col carries the current column. lb_pix field k (bits 8k+7:8k) returns the pixel of row field k in the same cycle.
- R7: Each output pixel is the signed sum of the four tap-times-pixel products, plus 32, arithmetically shifted right by 6, then clamped to 0..255.
- R8: One frame emits exactly out_h*line_w pixels, line by line, with columns 0..line_w-1 in order. busy falls when the last pixel is loaded. o_valid never rises while the block is idle.
- R9: A pixel transfers on a rising edge where o_valid and o_ready are both high. While o_valid is high and o_ready is low, o_valid and o_pix hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cf_we | input | 1 | Coefficient table write strobe |
| cf_idx | input | 5 | Phase index to write |
| cf_word | input | 32 | Four packed signed taps |
| cf_commit | input | 1 | Marks the table ready for use |
| start_frac | input | 16 | Starting fractional phase |
| step | input | 32 | 16.16 step per output line |
| in_h | input | 12 | Source height in rows |
| out_h | input | 12 | Output height in lines |
| line_w | input | 12 | Pixels per line |
| frame_start | input | 1 | Frame start pulse |
| lb_rows | output | 48 | Four clamped source row numbers |
| lb_col | output | 12 | Current column |
| lb_pix | input | 32 | Four source pixels for lb_rows/lb_col |
| o_valid | output | 1 | Output pixel valid |
| o_ready | input | 1 | Downstream ready |
| o_pix | output | 8 | Output pixel |
| busy | output | 1 | Frame in progress |

## Verification
The bench targets the image edges. It uses a start phase and a step that push row n-1 above the top and row n+2 below the bottom. A design that did not clamp there would fetch rows that do not exist and return wrong or zero pixels. A second coefficient set with strong negative lobes, applied to a high-contrast pattern, drives the sum below zero and above 255. A design that rounded with a logical shift or skipped the clamp would wrap those pixels. Random back-pressure and a frame_start pulse in the middle of a frame catch designs that drop or repeat a pixel, or restart the accumulator. A coefficient write made after a commit must block the next frame, and a design that kept the stale ready flag would start that frame anyway.

// File: rtl/vscale_pkg.sv
package vscale_pkg;
    localparam int PIX_W  = 8;
    localparam int COEF_W = 8;
    localparam int TAPS   = 4;
    localparam int PHASES = 32;
    localparam int PH_W   = $clog2(PHASES);
    localparam int WORD_W = TAPS * COEF_W;
    localparam int FRAC_W = 16;
    localparam int ACC_W  = 32;
    localparam int INT_W  = ACC_W - FRAC_W;
    localparam int SUM_W  = COEF_W + PIX_W + $clog2(TAPS) + 2;
    localparam int RND_SH = 6;

    typedef logic [TAPS-1:0][COEF_W-1:0] taps_t;
    typedef logic [TAPS-1:0][PIX_W-1:0]  pixv_t;

    typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

    function automatic logic [PIX_W-1:0] round_clamp(input logic signed [SUM_W-1:0] s);
        logic signed [SUM_W-1:0] r;
        logic signed [SUM_W-1:0] top;
        top = SUM_W'((1 << PIX_W) - 1);
        r = (s + SUM_W'(1 << (RND_SH - 1))) >>> RND_SH;
        if (r < 0)
            return '0;
        else if (r > top)
            return '1;
        else
            return r[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/vscale_coef_bank.sv
module vscale_coef_bank
    import vscale_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PH_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              commit,
    input  logic [PH_W-1:0]   rd_idx,
    output taps_t             rd_taps,
    output logic              ready
);
    logic [WORD_W-1:0] bank [PHASES];

    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b0;
            for (int p = 0; p < PHASES; p++)
                bank[p] <= '0;
        end else if (wr_en) begin
            bank[wr_idx] <= wr_word;
            ready        <= 1'b0;
        end else if (commit) begin
            ready <= 1'b1;
        end
    end

    assign rd_taps = taps_t'(bank[rd_idx]);
endmodule

// File: rtl/vscale_seq.sv
module vscale_seq
    import vscale_pkg::*;
#(
    parameter int DIM_W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  advance,
    input  logic [FRAC_W-1:0]     start_frac,
    input  logic [ACC_W-1:0]      step,
    input  logic [DIM_W-1:0]      in_h,
    input  logic [DIM_W-1:0]      out_h,
    input  logic [DIM_W-1:0]      line_w,
    output logic                  busy,
    output logic [PH_W-1:0]       phase,
    output logic [DIM_W-1:0]      col,
    output logic [TAPS*DIM_W-1:0] rows
);
    localparam int RW = INT_W + 2;

    seq_state_t          state;
    logic [ACC_W-1:0]    acc;
    logic [DIM_W-1:0]    x;
    logic [DIM_W-1:0]    y;
    logic                line_end;
    logic [INT_W-1:0]    base;
    logic signed [RW-1:0] h_ext;

    assign line_end = (x == line_w - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            acc   <= '0;
            x     <= '0;
            y     <= '0;
        end else if (start) begin
            state <= ST_RUN;
            acc   <= {{INT_W{1'b0}}, start_frac};
            x     <= '0;
            y     <= '0;
        end else if (state == ST_RUN && advance) begin
            if (line_end) begin
                x   <= '0;
                acc <= acc + step;
                if (y == out_h - 1'b1)
                    state <= ST_IDLE;
                else
                    y <= y + 1'b1;
            end else begin
                x <= x + 1'b1;
            end
        end
    end

    assign busy  = (state == ST_RUN);
    assign col   = x;
    assign phase = acc[FRAC_W-1 -: PH_W];
    assign base  = acc[ACC_W-1:FRAC_W];
    assign h_ext = $signed({{(RW-DIM_W){1'b0}}, in_h});

    for (genvar k = 0; k < TAPS; k++) begin : g_row
        logic signed [RW-1:0] want;
        assign want = $signed({2'b00, base}) + $signed(RW'(k)) - $signed(RW'(1));
        always_comb begin
            if (want < 0)
                rows[k*DIM_W +: DIM_W] = '0;
            else if (want >= h_ext)
                rows[k*DIM_W +: DIM_W] = in_h - 1'b1;
            else
                rows[k*DIM_W +: DIM_W] = want[DIM_W-1:0];
        end
    end
endmodule

// File: rtl/vscale_mac.sv
module vscale_mac
    import vscale_pkg::*;
(
    input  taps_t            taps,
    input  pixv_t            pix,
    output logic [PIX_W-1:0] result
);
    logic signed [SUM_W-1:0] acc_sum;

    always_comb begin
        logic signed [SUM_W-1:0] cw;
        logic signed [SUM_W-1:0] pw;
        acc_sum = '0;
        for (int k = 0; k < TAPS; k++) begin
            cw = {{(SUM_W-COEF_W){taps[k][COEF_W-1]}}, taps[k]};
            pw = {{(SUM_W-PIX_W){1'b0}}, pix[k]};
            acc_sum = acc_sum + cw * pw;
        end
    end

    assign result = round_clamp(acc_sum);
endmodule

// File: rtl/vscale_vert.sv
module vscale_vert
    import vscale_pkg::*;
#(
    parameter int DIM_W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cf_we,
    input  logic [PH_W-1:0]       cf_idx,
    input  logic [WORD_W-1:0]     cf_word,
    input  logic                  cf_commit,
    input  logic [FRAC_W-1:0]     start_frac,
    input  logic [ACC_W-1:0]      step,
    input  logic [DIM_W-1:0]      in_h,
    input  logic [DIM_W-1:0]      out_h,
    input  logic [DIM_W-1:0]      line_w,
    input  logic                  frame_start,
    output logic [TAPS*DIM_W-1:0] lb_rows,
    output logic [DIM_W-1:0]      lb_col,
    input  logic [TAPS*PIX_W-1:0] lb_pix,
    output logic                  o_valid,
    input  logic                  o_ready,
    output logic [PIX_W-1:0]      o_pix,
    output logic                  busy
);
    logic            coef_rdy;
    logic            go;
    logic            adv;
    logic [PH_W-1:0] phase;
    taps_t           taps;
    logic [PIX_W-1:0] filt;

    assign go  = frame_start && coef_rdy && !busy &&
                 (in_h != '0) && (out_h != '0) && (line_w != '0);
    assign adv = busy && (!o_valid || o_ready);

    vscale_coef_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cf_we),
        .wr_idx  (cf_idx),
        .wr_word (cf_word),
        .commit  (cf_commit),
        .rd_idx  (phase),
        .rd_taps (taps),
        .ready   (coef_rdy)
    );

    vscale_seq #(.DIM_W(DIM_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (go),
        .advance    (adv),
        .start_frac (start_frac),
        .step       (step),
        .in_h       (in_h),
        .out_h      (out_h),
        .line_w     (line_w),
        .busy       (busy),
        .phase      (phase),
        .col        (lb_col),
        .rows       (lb_rows)
    );

    vscale_mac u_mac (
        .taps   (taps),
        .pix    (pixv_t'(lb_pix)),
        .result (filt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_pix   <= '0;
        end else if (adv) begin
            o_valid <= 1'b1;
            o_pix   <= filt;
        end else if (o_ready) begin
            o_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/vscale_chk.sv
module vscale_chk
    import vscale_pkg::*;
#(
    parameter int DIM_W = 12
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  o_valid,
    input logic                  o_ready,
    input logic [PIX_W-1:0]      o_pix,
    input logic                  busy,
    input logic                  coef_rdy,
    input logic [DIM_W-1:0]      in_h,
    input logic [TAPS*DIM_W-1:0] lb_rows
);
    logic [DIM_W-1:0] r0, r1, r2, r3;
    assign r0 = lb_rows[0*DIM_W +: DIM_W];
    assign r1 = lb_rows[1*DIM_W +: DIM_W];
    assign r2 = lb_rows[2*DIM_W +: DIM_W];
    assign r3 = lb_rows[3*DIM_W +: DIM_W];

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!o_valid && !busy));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_pix)));

    // R3
    gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (!coef_rdy && !busy) |=> !busy);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !o_valid) |=> !o_valid);

    // R6
    row_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && in_h != '0) |-> (r3 < in_h));

    // R6
    row_order_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (r0 <= r1 && r1 <= r2 && r2 <= r3));
endmodule

bind vscale_vert vscale_chk #(.DIM_W(DIM_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .o_valid  (o_valid),
    .o_ready  (o_ready),
    .o_pix    (o_pix),
    .busy     (busy),
    .coef_rdy (coef_rdy),
    .in_h     (in_h),
    .lb_rows  (lb_rows)
);

// File: tb/vscale_vert_tb.sv
module vscale_vert_tb;
    localparam int DIM_W = 12;
    localparam int IMG_R = 16;
    localparam int IMG_C = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst = 1'b1;
    logic              cf_we = 1'b0;
    logic [4:0]        cf_idx = '0;
    logic [31:0]       cf_word = '0;
    logic              cf_commit = 1'b0;
    logic [15:0]       start_frac = '0;
    logic [31:0]       step = '0;
    logic [DIM_W-1:0]  in_h = '0, out_h = '0, line_w = '0;
    logic              frame_start = 1'b0;
    logic [4*DIM_W-1:0] lb_rows;
    logic [DIM_W-1:0]  lb_col;
    logic [31:0]       lb_pix;
    logic              o_valid;
    logic              o_ready = 1'b0;
    logic [7:0]        o_pix;
    logic              busy;

    vscale_vert #(.DIM_W(DIM_W)) u_dut (
        .clk(clk), .rst(rst), .cf_we(cf_we), .cf_idx(cf_idx), .cf_word(cf_word),
        .cf_commit(cf_commit), .start_frac(start_frac), .step(step), .in_h(in_h),
        .out_h(out_h), .line_w(line_w), .frame_start(frame_start), .lb_rows(lb_rows),
        .lb_col(lb_col), .lb_pix(lb_pix), .o_valid(o_valid), .o_ready(o_ready),
        .o_pix(o_pix), .busy(busy)
    );

    int img [IMG_R][IMG_C];
    int ctab [32][4];
    int exp_q [$];
    int total = 0;
    int bad = 0;
    int got = 0;
    int ready_mode = 0;
    bit prev_stall = 1'b0;
    logic [7:0] prev_pix = '0;
    string cur_tag = "R7";

    // line buffer model
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            int r;
            r = int'(lb_rows[k*DIM_W +: DIM_W]);
            if (r < IMG_R && int'(lb_col) < IMG_C)
                lb_pix[k*8 +: 8] = 8'(img[r][int'(lb_col)]);
            else
                lb_pix[k*8 +: 8] = 8'h00;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor and ready driver
    always @(negedge clk) begin
        if (rst) begin
            o_ready = 1'b0;
            prev_stall = 1'b0;
        end else begin
            if (prev_stall) begin
                chk(o_valid == 1'b1, "R9 valid held", int'(o_valid), 1);
                chk(o_pix == prev_pix, "R9 pixel held", int'(o_pix), int'(prev_pix));
            end
            o_ready = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
            if (o_valid && o_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 extra pixel", int'(o_pix), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(o_pix) == e, cur_tag, int'(o_pix), e);
                end
                got++;
            end
            prev_stall = o_valid && !o_ready;
            prev_pix = o_pix;
        end
    end

    task automatic build_expected(input int sf, input int st, input int ih, input int oh, input int w);
        exp_q.delete();
        for (int y = 0; y < oh; y++) begin
            longint a;
            int n, ph;
            a = (longint'(sf) + longint'(y) * longint'(st)) & 64'hFFFF_FFFF;
            n = int'(a >> 16);
            ph = int'((a >> 11) & 31);
            for (int x = 0; x < w; x++) begin
                int s, v;
                s = 0;
                for (int k = 0; k < 4; k++) begin
                    int r;
                    r = n + k - 1;
                    if (r < 0) r = 0;
                    if (r > ih - 1) r = ih - 1;
                    s += ctab[ph][k] * img[r][x];
                end
                v = (s + 32) >>> 6;
                if (v < 0) v = 0;
                if (v > 255) v = 255;
                exp_q.push_back(v);
            end
        end
    endtask

    task automatic load_table(input bit do_commit);
        for (int p = 0; p < 32; p++) begin
            cf_we = 1'b1;
            cf_idx = 5'(p);
            cf_word = {8'(ctab[p][3]), 8'(ctab[p][2]), 8'(ctab[p][1]), 8'(ctab[p][0])};
            @(negedge clk);
        end
        cf_we = 1'b0;
        if (do_commit) begin
            cf_commit = 1'b1;
            @(negedge clk);
            cf_commit = 1'b0;
        end
    endtask

    task automatic run_frame(input int sf, input int ih, input int oh, input int w,
                             input bit mid_pulse, input string tag);
        int cyc;
        start_frac = 16'(sf);
        in_h = DIM_W'(ih);
        out_h = DIM_W'(oh);
        line_w = DIM_W'(w);
        step = 32'((longint'(ih) << 16) / oh);
        cur_tag = tag;
        build_expected(sf, int'(step), ih, oh, w);
        got = 0;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        chk(busy == 1'b1, "R4 busy after start", int'(busy), 1);
        cyc = 0;
        while (busy || o_valid) begin
            @(negedge clk);
            cyc++;
            frame_start = mid_pulse && (cyc == 6);
        end
        frame_start = 1'b0;
        @(negedge clk);
        chk(got == oh * w, "R8 pixel count", got, oh * w);
        chk(exp_q.size() == 0, "R8 leftover", exp_q.size(), 0);
        chk(busy == 1'b0, "R8 idle at end", int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < IMG_R; r++)
            for (int c = 0; c < IMG_C; c++)
                img[r][c] = (r * 37 + c * 91 + 13) & 255;
        for (int p = 0; p < 32; p++) begin
            ctab[p][0] = -(p >> 2);
            ctab[p][1] = 64 - 2 * p;
            ctab[p][2] = 2 * p;
            ctab[p][3] = p >> 2;
        end

        repeat (3) @(negedge clk);
        chk(o_valid == 1'b0, "R1 valid in reset", int'(o_valid), 0);
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(o_valid == 1'b0, "R1 valid after reset", int'(o_valid), 0);

        // R1 / R3: no commit yet, start ignored
        in_h = 8; out_h = 4; line_w = 4; step = 32'h0002_0000;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (8) @(negedge clk);
        chk(busy == 1'b0, "R1 R3 start before commit", int'(busy), 0);
        chk(got == 0, "R3 no output before commit", got, 0);

        // R3: table written without commit still blocks
        load_table(1'b0);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R3 uncommitted table", int'(busy), 0);

        cf_commit = 1'b1;
        @(negedge clk);
        cf_commit = 1'b0;

        // upscale, random back-pressure, mid-frame start pulse ignored
        ready_mode = 1;
        run_frame(0, 8, 12, 5, 1'b1, "R2 R3 R5 R9");

        // downscale with half-row starting phase
        ready_mode = 0;
        run_frame(16'h8000, 12, 5, 6, 1'b0, "R4 R5");

        // R3: a write after commit clears ready
        cf_we = 1'b1; cf_idx = 5'd3;
        cf_word = {8'(ctab[3][3]), 8'(ctab[3][2]), 8'(ctab[3][1]), 8'(ctab[3][0])};
        @(negedge clk);
        cf_we = 1'b0;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R3 write cleared ready", int'(busy), 0);
        chk(o_valid == 1'b0, "R3 no pixel", int'(o_valid), 0);

        // sharpening taps on a high-contrast pattern: edges and clamping
        for (int p = 0; p < 32; p++) begin
            ctab[p][0] = -16;
            ctab[p][1] = 96 - 2 * p;
            ctab[p][2] = 2 * p - 16;
            ctab[p][3] = 0;
        end
        for (int r = 0; r < IMG_R; r++)
            for (int c = 0; c < IMG_C; c++)
                img[r][c] = (r == 1 || r == 3 || c == 2) ? 255 : 0;
        load_table(1'b1);
        ready_mode = 1;
        run_frame(16'hC000, 4, 7, 8, 1'b0, "R6 R7");

        // smallest frame
        ready_mode = 0;
        run_frame(16'h4000, 1, 1, 1, 1'b0, "R6 R8");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule